// File: doc/BRIEF.md
# MOESI Snooping Line Coherence Controller

This block keeps the coherence state of one line of a private cache that sits on a shared snooping bus. It takes processor requests (read, write, read-for-ownership, replacement) and snooped requests from the other caches (read, write/invalidate). From these it works out the line's next state among Modified, Owned, Exclusive, Shared and Invalid. It also drives the bus command the cache must issue and the responses it owes the bus.

The shared response line tells a missing reader whether any other cache holds a copy, so that the reader installs the line as Shared rather than Exclusive. When the line is dirty (Modified or Owned), the controller asserts the supply line. This passes its value straight to the requesting cache and holds memory back from answering, so memory is not updated. A dirty line reaches memory only through a writeback on replacement.

All bus responses are combinational in the cycle of the request, and the state register and line data update at the next rising edge. A snoop and a processor request in the same cycle resolve in favour of the snoop, and the processor must retry.

Top module: `moesi_line_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the line state is Invalid (state code 0), the line data is zero, and `bus_cmd`, `wb_valid`, `snp_shared`, `snp_supply`, `wb_data` and `snp_data` are all zero.
- R2: A processor read (`cpu_op`=1) on an Invalid line issues `bus_cmd`=1 (read) in that cycle and loads `fill_data`. The next state is Exclusive (code 2) when `fill_shared` is low and Shared (code 1) when it is high.
- R3: A processor read, or no request (`cpu_op`=0), on a valid line issues no bus command and leaves the state and data unchanged.
- R4: A processor write (`cpu_op`=2) to an Exclusive or Modified line issues no bus command, stores `cpu_wdata` and moves the line to Modified (code 4).
- R5: A processor write to a Shared or Owned (code 3) line issues `bus_cmd`=2 (invalidate others), stores `cpu_wdata` and moves the line to Modified.
- R6: A processor write to an Invalid line issues `bus_cmd`=3 (read-for-ownership), stores `cpu_wdata` and moves the line to Modified.
- R7: A read-for-ownership (`cpu_op`=3) issues `bus_cmd`=3 from Invalid, Shared or Owned, and is silent from Exclusive or Modified. Invalid moves to Exclusive with `fill_data`, Shared moves to Exclusive keeping its data, Owned moves to Modified, and Exclusive and Modified are unchanged.
- R8: A snooped read (`snp_op`=1) on any valid line raises `snp_shared`. On Modified or Owned it also raises `snp_supply` and drives the line data on `snp_data`. The transitions are Modified to Owned and Exclusive to Shared, and Shared and Owned keep their state. An Invalid line gives no response.
- R9: A snooped write (`snp_op`=2) moves any line to Invalid at the next edge. A Modified or Owned line raises `snp_supply` and drives its data in that cycle. No writeback is issued.
- R10: A replacement (`cpu_op`=4) on a Modified or Owned line raises `wb_valid` with the line data on `wb_data`. Any replacement leaves the line Invalid, and only dirty lines write back.
- R11: While a snoop is present, the processor request is ignored: no bus command, no writeback, and no change to the data from the processor side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 3 | Processor request: 0 none, 1 read, 2 write, 3 read-for-ownership, 4 replace |
| cpu_wdata | input | DATA_W | Processor write value |
| fill_data | input | DATA_W | Value returned by the bus for this cycle's read or read-for-ownership |
| fill_shared | input | 1 | Another cache answered this cycle's read with its shared line |
| snp_op | input | 2 | Snooped request from another cache: 0 none, 1 read, 2 write, 3 none |
| bus_cmd | output | 2 | Command this cache issues: 0 none, 1 read, 2 invalidate, 3 read-for-ownership |
| wb_valid | output | 1 | Writeback of dirty data to memory this cycle |
| wb_data | output | DATA_W | Writeback value, zero when idle |
| snp_shared | output | 1 | Shared response to a snooped read |
| snp_supply | output | 1 | This cache drives the data and inhibits memory |
| snp_data | output | DATA_W | Supplied value, zero when not supplying |
| state_out | output | 3 | Current state: 0 I, 1 S, 2 E, 3 O, 4 M |
| rdata | output | DATA_W | Current line data |

## Verification
The bench brings the line into each of the five states by legal sequences. From each one it tries every processor request against every snoop kind and both values of the shared input. It compares the bus responses, the next state and the stored data with values derived from the rules above.

The bench goes after several corner cases in particular:
- A controller that wrote back on a snooped read of a dirty line, or forgot to supply data from Owned, would show the wrong response vector.
- A controller that upgraded Exclusive with a bus message, or Shared without one, would show the wrong command.
- A controller that let a processor write slip through beside a snoop would corrupt the stored value or issue a stray command.
- A controller that let a clean line write back on replacement would raise `wb_valid` when it should stay low.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_RD    = 3'd1;
    localparam logic [2:0] OP_WR    = 3'd2;
    localparam logic [2:0] OP_RFO   = 3'd3;
    localparam logic [2:0] OP_EVICT = 3'd4;

    localparam logic [1:0] SN_NONE  = 2'd0;
    localparam logic [1:0] SN_RD    = 2'd1;
    localparam logic [1:0] SN_WR    = 2'd2;

    localparam logic [1:0] BUS_NONE = 2'd0;
    localparam logic [1:0] BUS_RD   = 2'd1;
    localparam logic [1:0] BUS_INV  = 2'd2;
    localparam logic [1:0] BUS_RFO  = 2'd3;

    function automatic logic is_dirty(line_state_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction
endpackage

// File: rtl/moesi_next_state.sv
module moesi_next_state
    import moesi_pkg::*;
(
    input  line_state_e st,
    input  logic [2:0]  cpu_op,
    input  logic [1:0]  snp_op,
    input  logic        fill_shared,
    output line_state_e nxt,
    output logic [1:0]  bus_cmd,
    output logic        ld_fill,
    output logic        ld_wdata,
    output logic        wb_fire
);
    always_comb begin
        nxt      = st;
        bus_cmd  = BUS_NONE;
        ld_fill  = 1'b0;
        ld_wdata = 1'b0;
        wb_fire  = 1'b0;
        if (snp_op == SN_RD) begin
            unique case (st)
                ST_M:    nxt = ST_O;
                ST_E:    nxt = ST_S;
                default: nxt = st;
            endcase
        end else if (snp_op == SN_WR) begin
            nxt = ST_I;
        end else begin
            unique case (cpu_op)
                OP_RD: begin
                    if (st == ST_I) begin
                        bus_cmd = BUS_RD;
                        ld_fill = 1'b1;
                        nxt     = fill_shared ? ST_S : ST_E;
                    end
                end
                OP_WR: begin
                    ld_wdata = 1'b1;
                    nxt      = ST_M;
                    unique case (st)
                        ST_I:       bus_cmd = BUS_RFO;
                        ST_S, ST_O: bus_cmd = BUS_INV;
                        default:    bus_cmd = BUS_NONE;
                    endcase
                end
                OP_RFO: begin
                    unique case (st)
                        ST_I: begin
                            bus_cmd = BUS_RFO;
                            ld_fill = 1'b1;
                            nxt     = ST_E;
                        end
                        ST_S: begin
                            bus_cmd = BUS_RFO;
                            nxt     = ST_E;
                        end
                        ST_O: begin
                            bus_cmd = BUS_RFO;
                            nxt     = ST_M;
                        end
                        default: nxt = st;
                    endcase
                end
                OP_EVICT: begin
                    wb_fire = is_dirty(st);
                    nxt     = ST_I;
                end
                default: nxt = st;
            endcase
        end
    end
endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
    import moesi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  line_state_e        st,
    input  logic [1:0]         snp_op,
    input  logic [DATA_W-1:0]  line_data,
    output logic               snp_shared,
    output logic               snp_supply,
    output logic [DATA_W-1:0]  snp_data
);
    always_comb begin
        snp_shared = 1'b0;
        snp_supply = 1'b0;
        snp_data   = '0;
        if ((snp_op == SN_RD || snp_op == SN_WR) && st != ST_I) begin
            snp_shared = (snp_op == SN_RD);
            if (is_dirty(st)) begin
                snp_supply = 1'b1;
                snp_data   = line_data;
            end
        end
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_op,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_shared,
    input  logic [1:0]        snp_op,
    output logic [1:0]        bus_cmd,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output logic [2:0]        state_out,
    output logic [DATA_W-1:0] rdata
);
    line_state_e        state_q;
    line_state_e        state_d;
    logic [DATA_W-1:0]  data_q;
    logic               ld_fill;
    logic               ld_wdata;
    logic               wb_fire;

    moesi_next_state u_next (
        .st          (state_q),
        .cpu_op      (cpu_op),
        .snp_op      (snp_op),
        .fill_shared (fill_shared),
        .nxt         (state_d),
        .bus_cmd     (bus_cmd),
        .ld_fill     (ld_fill),
        .ld_wdata    (ld_wdata),
        .wb_fire     (wb_fire)
    );

    moesi_snoop_resp #(.DATA_W(DATA_W)) u_resp (
        .st          (state_q),
        .snp_op      (snp_op),
        .line_data   (data_q),
        .snp_shared  (snp_shared),
        .snp_supply  (snp_supply),
        .snp_data    (snp_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_I;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ld_wdata)
                data_q <= cpu_wdata;
            else if (ld_fill)
                data_q <= fill_data;
        end
    end

    always_comb begin
        wb_valid  = wb_fire;
        wb_data   = wb_fire ? data_q : '0;
        state_out = state_q;
        rdata     = data_q;
    end
endmodule

// File: rtl/moesi_line_sva.sv
module moesi_line_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cpu_op,
    input logic [1:0] snp_op,
    input logic [2:0] state_out,
    input logic [1:0] bus_cmd,
    input logic       wb_valid,
    input logic       snp_shared,
    input logic       snp_supply
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_out <= 3'd4);

    assert_dirty_read_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'd1 && state_out == 3'd4) |=> state_out == 3'd3);

    assert_supply_from_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (state_out == 3'd4 || state_out == 3'd3));

    assert_snoop_write_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'd2) |=> state_out == 3'd0);

    assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'd0 && cpu_op == 3'd2 && state_out == 3'd2) |-> bus_cmd == 2'd0);

    assert_wb_dirty_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (state_out == 3'd4 || state_out == 3'd3));

    assert_snoop_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'd1 || snp_op == 2'd2) |-> (bus_cmd == 2'd0 && !wb_valid));

    assert_shared_needs_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> state_out != 3'd0);
endmodule

bind moesi_line_ctrl moesi_line_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_op     (cpu_op),
    .snp_op     (snp_op),
    .state_out  (state_out),
    .bus_cmd    (bus_cmd),
    .wb_valid   (wb_valid),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply)
);

// File: tb/sim_moesi_line_ctrl.sv
module sim_moesi_line_ctrl;
    localparam int W = 32;
    localparam logic [W-1:0] DS = 32'h5A5A_0001;
    localparam logic [W-1:0] DE = 32'hE0E0_0002;
    localparam logic [W-1:0] DM = 32'hD1D1_0003;
    localparam logic [W-1:0] FL = 32'hF00D_0004;
    localparam logic [W-1:0] WD = 32'hBEEF_0005;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cpu_op = 3'd0;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] fill_data = '0;
    logic         fill_shared = 1'b0;
    logic [1:0]   snp_op = 2'd0;
    logic [1:0]   bus_cmd;
    logic         wb_valid;
    logic [W-1:0] wb_data;
    logic         snp_shared;
    logic         snp_supply;
    logic [W-1:0] snp_data;
    logic [2:0]   state_out;
    logic [W-1:0] rdata;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] cur_d;

    always #2 clk = ~clk;

    moesi_line_ctrl #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .fill_data(fill_data), .fill_shared(fill_shared), .snp_op(snp_op),
        .bus_cmd(bus_cmd), .wb_valid(wb_valid), .wb_data(wb_data),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data),
        .state_out(state_out), .rdata(rdata)
    );

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        cpu_op = 3'd0; snp_op = 2'd0; fill_shared = 1'b0;
        fill_data = '0; cpu_wdata = '0;
    endtask

    // drive at a falling edge, let the rising edge pass, return at the next falling edge
    task automatic step(logic [2:0] op, logic [1:0] sn, logic sh,
                        logic [W-1:0] fd, logic [W-1:0] wd);
        cpu_op = op; snp_op = sn; fill_shared = sh; fill_data = fd; cpu_wdata = wd;
        @(negedge clk);
        drive_idle();
    endtask

    task automatic do_reset();
        drive_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reach(int st);
        do_reset();
        cur_d = '0;
        case (st)
            1: begin step(3'd1, 2'd0, 1'b1, DS, '0); cur_d = DS; end
            2: begin step(3'd1, 2'd0, 1'b0, DE, '0); cur_d = DE; end
            3: begin
                step(3'd1, 2'd0, 1'b0, DE, '0);
                step(3'd2, 2'd0, 1'b0, '0, DM);
                step(3'd0, 2'd1, 1'b0, '0, '0);
                cur_d = DM;
            end
            4: begin
                step(3'd1, 2'd0, 1'b0, DE, '0);
                step(3'd2, 2'd0, 1'b0, '0, DM);
                cur_d = DM;
            end
            default: cur_d = '0;
        endcase
    endtask

    function automatic string req_of(int st, int op, int sn);
        if (sn != 0 && op != 0) return "R11";
        if (sn == 1) return "R8";
        if (sn == 2) return "R9";
        case (op)
            1: return (st == 0) ? "R2" : "R3";
            2: return (st == 0) ? "R6" : ((st == 2 || st == 4) ? "R4" : "R5");
            3: return "R7";
            4: return "R10";
            default: return "R3";
        endcase
    endfunction

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: values held during reset
        check("R1", {state_out, rdata}, {3'd0, {W{1'b0}}});
        check("R1", {bus_cmd, wb_valid, wb_data, snp_shared, snp_supply, snp_data},
              {2'd0, 1'b0, {W{1'b0}}, 1'b0, 1'b0, {W{1'b0}}});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {state_out, rdata}, {3'd0, {W{1'b0}}});

        for (int st = 0; st < 5; st++) begin
            for (int op = 0; op < 5; op++) begin
                for (int sn = 0; sn < 3; sn++) begin
                    for (int sh = 0; sh < 2; sh++) begin
                        logic [1:0]   e_bus;
                        logic         e_wb, e_sh, e_sup;
                        logic [W-1:0] e_wbd, e_snd, e_d;
                        int           e_st;
                        logic         dirty;
                        string        req;
                        reach(st);
                        check("R1", {29'd0, state_out}, st);
                        dirty = (st == 3 || st == 4);
                        e_bus = 2'd0; e_wb = 1'b0; e_sh = 1'b0; e_sup = 1'b0;
                        e_wbd = '0; e_snd = '0; e_d = cur_d; e_st = st;
                        if (sn == 1) begin
                            e_sh  = (st != 0);
                            e_sup = dirty;
                            e_snd = dirty ? cur_d : '0;
                            if (st == 4) e_st = 3;
                            else if (st == 2) e_st = 1;
                        end else if (sn == 2) begin
                            e_sup = dirty;
                            e_snd = dirty ? cur_d : '0;
                            e_st  = 0;
                        end else begin
                            case (op)
                                1: if (st == 0) begin
                                    e_bus = 2'd1; e_d = FL; e_st = sh ? 1 : 2;
                                end
                                2: begin
                                    e_bus = (st == 0) ? 2'd3 :
                                            ((st == 1 || st == 3) ? 2'd2 : 2'd0);
                                    e_d = WD; e_st = 4;
                                end
                                3: begin
                                    if (st == 0) begin e_bus = 2'd3; e_d = FL; e_st = 2; end
                                    else if (st == 1) begin e_bus = 2'd3; e_st = 2; end
                                    else if (st == 3) begin e_bus = 2'd3; e_st = 4; end
                                end
                                4: begin
                                    e_wb = dirty; e_wbd = dirty ? cur_d : '0; e_st = 0;
                                end
                                default: ;
                            endcase
                        end
                        req = req_of(st, op, sn);
                        cpu_op = op[2:0]; snp_op = sn[1:0]; fill_shared = sh[0];
                        fill_data = FL; cpu_wdata = WD;
                        #1;
                        check(req, {bus_cmd, wb_valid, wb_data, snp_shared, snp_supply, snp_data},
                              {e_bus, e_wb, e_wbd, e_sh, e_sup, e_snd});
                        @(negedge clk);
                        drive_idle();
                        check(req, {29'd0, state_out}, e_st);
                        if (e_st != 0)
                            check(req, rdata, e_d);
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule